// File: doc/BRIEF.md
# Dual Line Instruction Prefetch Queue

This block sits between an instruction memory port and the first decode stage. It holds two 16-byte line buffers that are used in alternation. While decode works through one line, the other line is fetched, or is already waiting. The fetch side runs on its own: whenever a buffer slot is free, it issues a line request to memory, whether or not decode is taking bytes at that moment.

Decode sees a byte-aligned window of up to eight consecutive instruction bytes. The window can cross from one line buffer into the next. Decode reports how many bytes it used each cycle, from zero to eight. It may take a short leading piece first (for example, opcode bytes) and the rest of the instruction in a later cycle. When a line has been fully consumed, its slot is released and refilled.

A branch redirect flushes both buffers and restarts fetching at the line that holds the target. The bytes in front of an unaligned target are skipped. A line that was still in flight at the time of the flush is recognised by its request tag and thrown away.

Top module: `pfq_prefetch_queue`

Fetch state machine: `FS_IDLE` (waiting for the next slot to become free), `FS_REQ` (request held on the port) and `FS_WAIT` (waiting for the response with the current tag).
- Transitions: `FS_IDLE->FS_REQ` when the next fill slot is empty; `FS_REQ->FS_WAIT` on acceptance; `FS_WAIT->FS_IDLE` on a response with a matching tag.
- A flush forces `FS_REQ` from every state.

## Requirements
- R1: While reset is held, `win_count` is 0, `mem_req_valid` is 0 and `consume_err` is 0.
- R2: Every accepted request carries a 16-byte-aligned address. Addresses rise by 16 from the flush target's line, or from address 0 after reset. The request tag equals a flush counter that starts at 0 after reset and increments by 1 (modulo 4) on each flush.
- R3: A request that is not accepted stays asserted, with the same address and tag, in the next cycle, unless a flush occurs.
- R4: The number of lines held plus requests in flight never exceeds two. Fetching continues while decode consumes nothing, so a stalled decoder ends up with two full lines (32 bytes) in the buffers.
- R5: `win_count` equals the minimum of 8 and the number of buffered bytes. Window byte i (bits 8i+7..8i) is the i-th byte from the read point, including across the line boundary.
- R6: A consume value no larger than `win_count` advances the read point by that many bytes. A larger value changes nothing and raises `consume_err` in the following cycle only.
- R7: A line slot is released once all 16 of its bytes have been consumed, and a refill request for it follows.
- R8: A flush empties the window in the next cycle. Fetching restarts at the target's line, and the first bytes shown are those from the target address onward.
- R9: A response whose tag differs from the current flush counter, or which arrives in the flush cycle itself, leaves the window unchanged.
- R10: In the flush cycle the consume input is ignored, and `consume_err` is 0 in the cycle after a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Redirect: discard buffered bytes and restart fetching |
| flush_addr | input | 32 | Byte address of the redirect target |
| mem_req_valid | output | 1 | Line request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Line-aligned request address |
| mem_req_tag | output | 2 | Flush-counter tag of the request |
| mem_rsp_valid | input | 1 | Line response valid |
| mem_rsp_tag | input | 2 | Tag returned with the line |
| mem_rsp_data | input | 128 | Line bytes, byte b at bits 8b+7..8b |
| win_data | output | 64 | Decode window, byte i at bits 8i+7..8i |
| win_count | output | 4 | Number of valid window bytes, 0 to 8 |
| consume | input | 4 | Bytes taken by decode this cycle |
| consume_err | output | 1 | Previous cycle's consume value exceeded the count |

## Verification
The hardest case to reach is a flush that lands while an older line request is still outstanding. The stale line then has to arrive after the new tag is in force, or exactly in the flush cycle. The bench reaches this by holding its memory model's responses back until a request has been accepted, and only then issuing the flush. When the responses are released, the stale line is delivered first, ahead of the new request's line. The reference model tracks tags, so any byte taken from the dropped line shows up as a window mismatch.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_WAIT = 2'd2
    } fetch_state_e;
endpackage

// File: rtl/pfq_fetch_fsm.sv
module pfq_fetch_fsm
    import pfq_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter int              LINE_BYTES = 16,
    parameter int              TAG_W      = 2,
    parameter bit [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_addr,
    input  logic [1:0]        slot_valid,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [TAG_W-1:0]  mem_rsp_tag,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [TAG_W-1:0]  mem_req_tag,
    output logic              fill_we,
    output logic              fill_slot
);
    localparam int OFF_W = $clog2(LINE_BYTES);

    fetch_state_e      state_q, state_d;
    logic [ADDR_W-1:0] line_q;
    logic [TAG_W-1:0]  epoch_q;
    logic              slot_q;
    logic              rsp_hit;

    // a line is taken only when it answers the live request of this epoch
    assign rsp_hit = (state_q == FS_WAIT) && mem_rsp_valid
                   && (mem_rsp_tag == epoch_q) && !flush;

    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = FS_REQ;
        end else begin
            unique case (state_q)
                FS_IDLE: if (!slot_valid[slot_q]) state_d = FS_REQ;
                FS_REQ:  if (mem_req_ready)       state_d = FS_WAIT;
                FS_WAIT: if (rsp_hit)             state_d = FS_IDLE;
                default:                          state_d = FS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q  <= {RESET_ADDR[ADDR_W-1:OFF_W], OFF_W'(0)};
            epoch_q <= '0;
            slot_q  <= 1'b0;
        end else if (flush) begin
            line_q  <= {flush_addr[ADDR_W-1:OFF_W], OFF_W'(0)};
            epoch_q <= epoch_q + 1'b1;
            slot_q  <= 1'b0;
        end else if (rsp_hit) begin
            line_q  <= line_q + ADDR_W'(LINE_BYTES);
            slot_q  <= ~slot_q;
        end
    end

    always_comb begin
        mem_req_valid = (state_q == FS_REQ);
        mem_req_addr  = line_q;
        mem_req_tag   = epoch_q;
        fill_we       = rsp_hit;
        fill_slot     = slot_q;
    end
endmodule

// File: rtl/pfq_line_store.sv
module pfq_line_store #(
    parameter int LINE_BYTES = 16,
    parameter int WIN_BYTES  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      fill_we,
    input  logic                      fill_slot,
    input  logic [LINE_BYTES*8-1:0]   fill_data,
    input  logic                      free_we,
    input  logic                      free_slot,
    input  logic                      rd_slot,
    input  logic [$clog2(LINE_BYTES)-1:0] rd_off,
    output logic [1:0]                slot_valid,
    output logic [WIN_BYTES*8-1:0]    win_data,
    output logic [$clog2(2*LINE_BYTES+1)-1:0] avail
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int AV_W  = $clog2(2*LINE_BYTES+1);

    logic [7:0] bytes_q [2][LINE_BYTES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_valid <= 2'b00;
        end else begin
            for (int s = 0; s < 2; s++) begin
                if (flush)                                slot_valid[s] <= 1'b0;
                else if (fill_we && fill_slot == 1'(s))   slot_valid[s] <= 1'b1;
                else if (free_we && free_slot == 1'(s))   slot_valid[s] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < 2; s++) begin
            if (fill_we && fill_slot == 1'(s)) begin
                for (int b = 0; b < LINE_BYTES; b++) begin
                    bytes_q[s][b] <= fill_data[8*b +: 8];
                end
            end
        end
    end

    // window byte i wraps into the partner line once the offset passes the end
    for (genvar i = 0; i < WIN_BYTES; i++) begin : g_win
        logic [OFF_W:0] pos;
        assign pos = {1'b0, rd_off} + (OFF_W+1)'(i);
        assign win_data[8*i +: 8] = pos[OFF_W] ? bytes_q[~rd_slot][pos[OFF_W-1:0]]
                                               : bytes_q[rd_slot][pos[OFF_W-1:0]];
    end

    always_comb begin
        avail = '0;
        if (slot_valid[rd_slot]) begin
            avail = AV_W'(LINE_BYTES) - AV_W'(rd_off);
            if (slot_valid[~rd_slot]) avail = avail + AV_W'(LINE_BYTES);
        end
    end
endmodule

// File: rtl/pfq_read_ctrl.sv
module pfq_read_ctrl #(
    parameter int              ADDR_W     = 32,
    parameter int              LINE_BYTES = 16,
    parameter int              WIN_BYTES  = 8,
    parameter bit [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  flush,
    input  logic [ADDR_W-1:0]                     flush_addr,
    input  logic [$clog2(WIN_BYTES+1)-1:0]        consume,
    input  logic [$clog2(2*LINE_BYTES+1)-1:0]     avail,
    output logic                                  rd_slot,
    output logic [$clog2(LINE_BYTES)-1:0]         rd_off,
    output logic [$clog2(WIN_BYTES+1)-1:0]        win_count,
    output logic                                  free_we,
    output logic                                  free_slot,
    output logic                                  consume_err
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int AV_W  = $clog2(2*LINE_BYTES+1);
    localparam int CN_W  = $clog2(WIN_BYTES+1);

    logic           over;
    logic           adv;
    logic [OFF_W:0] sum;

    assign win_count = (avail > AV_W'(WIN_BYTES)) ? CN_W'(WIN_BYTES) : CN_W'(avail);
    assign over      = consume > win_count;
    assign adv       = !flush && !over;
    assign sum       = {1'b0, rd_off} + (OFF_W+1)'(consume);
    assign free_we   = adv && sum[OFF_W];
    assign free_slot = rd_slot;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_slot     <= 1'b0;
            rd_off      <= RESET_ADDR[OFF_W-1:0];
            consume_err <= 1'b0;
        end else begin
            consume_err <= !flush && over;
            if (flush) begin
                rd_slot <= 1'b0;
                rd_off  <= flush_addr[OFF_W-1:0];
            end else if (adv) begin
                rd_off  <= sum[OFF_W-1:0];
                rd_slot <= rd_slot ^ sum[OFF_W];
            end
        end
    end
endmodule

// File: rtl/pfq_prefetch_queue.sv
module pfq_prefetch_queue #(
    parameter int              ADDR_W     = 32,
    parameter int              LINE_BYTES = 16,
    parameter int              WIN_BYTES  = 8,
    parameter int              TAG_W      = 2,
    parameter bit [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               flush,
    input  logic [ADDR_W-1:0]                  flush_addr,
    output logic                               mem_req_valid,
    input  logic                               mem_req_ready,
    output logic [ADDR_W-1:0]                  mem_req_addr,
    output logic [TAG_W-1:0]                   mem_req_tag,
    input  logic                               mem_rsp_valid,
    input  logic [TAG_W-1:0]                   mem_rsp_tag,
    input  logic [LINE_BYTES*8-1:0]            mem_rsp_data,
    output logic [WIN_BYTES*8-1:0]             win_data,
    output logic [$clog2(WIN_BYTES+1)-1:0]     win_count,
    input  logic [$clog2(WIN_BYTES+1)-1:0]     consume,
    output logic                               consume_err
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int AV_W  = $clog2(2*LINE_BYTES+1);

    logic [1:0]      slot_valid;
    logic            fill_we, fill_slot;
    logic            free_we, free_slot;
    logic            rd_slot;
    logic [OFF_W-1:0] rd_off;
    logic [AV_W-1:0] avail;

    pfq_fetch_fsm #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .TAG_W(TAG_W), .RESET_ADDR(RESET_ADDR)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
        .slot_valid(slot_valid), .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_tag(mem_req_tag), .fill_we(fill_we), .fill_slot(fill_slot)
    );

    pfq_line_store #(
        .LINE_BYTES(LINE_BYTES), .WIN_BYTES(WIN_BYTES)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .fill_we(fill_we), .fill_slot(fill_slot), .fill_data(mem_rsp_data),
        .free_we(free_we), .free_slot(free_slot),
        .rd_slot(rd_slot), .rd_off(rd_off),
        .slot_valid(slot_valid), .win_data(win_data), .avail(avail)
    );

    pfq_read_ctrl #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .WIN_BYTES(WIN_BYTES), .RESET_ADDR(RESET_ADDR)
    ) u_read (
        .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
        .consume(consume), .avail(avail),
        .rd_slot(rd_slot), .rd_off(rd_off), .win_count(win_count),
        .free_we(free_we), .free_slot(free_slot), .consume_err(consume_err)
    );
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int WIN_BYTES  = 8,
    parameter int TAG_W      = 2
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           flush,
    input logic                           mem_req_valid,
    input logic                           mem_req_ready,
    input logic [ADDR_W-1:0]              mem_req_addr,
    input logic [TAG_W-1:0]               mem_req_tag,
    input logic                           mem_rsp_valid,
    input logic [WIN_BYTES*8-1:0]         win_data,
    input logic [$clog2(WIN_BYTES+1)-1:0] win_count,
    input logic [$clog2(WIN_BYTES+1)-1:0] consume,
    input logic                           consume_err
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int CN_W  = $clog2(WIN_BYTES+1);

    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0)); // R2

    AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (mem_req_tag == TAG_W'($past(mem_req_tag) + 1'b1))); // R2

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready && !flush) |=>
        (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_tag))); // R3

    AST_WIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        win_count <= CN_W'(WIN_BYTES)); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && consume == '0 && !mem_rsp_valid) |=>
        ($stable(win_count) && $stable(win_data))); // R6

    AST_OVER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && consume > win_count) |=> consume_err); // R6

    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(consume > win_count) |=> !consume_err); // R6

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (win_count == '0)); // R8

    AST_FLUSH_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !consume_err); // R10
endmodule

bind pfq_prefetch_queue pfq_checker #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .WIN_BYTES(WIN_BYTES), .TAG_W(TAG_W)
) u_pfq_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
    .mem_rsp_valid(mem_rsp_valid), .win_data(win_data), .win_count(win_count),
    .consume(consume), .consume_err(consume_err)
);

// File: tb/pfq_prefetch_queue_bench.sv
module pfq_prefetch_queue_bench;
    localparam int ADDR_W = 32;
    localparam int LINE   = 16;
    localparam int WIN    = 8;
    localparam int TAG_W  = 2;
    localparam int CN_W   = 4;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                flush = 1'b0;
    logic [ADDR_W-1:0]   flush_addr = '0;
    logic                mem_req_valid;
    logic                mem_req_ready = 1'b0;
    logic [ADDR_W-1:0]   mem_req_addr;
    logic [TAG_W-1:0]    mem_req_tag;
    logic                mem_rsp_valid = 1'b0;
    logic [TAG_W-1:0]    mem_rsp_tag = '0;
    logic [LINE*8-1:0]   mem_rsp_data = '0;
    logic [WIN*8-1:0]    win_data;
    logic [CN_W-1:0]     win_count;
    logic [CN_W-1:0]     consume = '0;
    logic                consume_err;

    always #10 clk = ~clk;

    pfq_prefetch_queue u_pfq_prefetch_queue (
        .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag),
        .mem_rsp_data(mem_rsp_data), .win_data(win_data),
        .win_count(win_count), .consume(consume), .consume_err(consume_err)
    );

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    logic [7:0]  mq[$];
    logic [31:0] pa[$];
    int          pt[$];
    int          epoch = 0;
    logic [31:0] next_addr = 0;
    logic [31:0] head_addr = 0;
    int          skip = 0;
    int          outst = 0;
    bit          err_exp = 0;
    bit          ready_en = 0;
    bit          rsp_en = 0;
    bit          hold_prev = 0;
    logic [31:0] hold_addr = 0;

    function automatic logic [7:0] mbyte(logic [31:0] a);
        return 8'(a * 13 + (a >> 4) * 7 + 5);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic compare_outputs();
        int wc;
        int held;
        wc = (mq.size() > WIN) ? WIN : mq.size();
        chk(win_count == CN_W'(wc), "R5 count", win_count, wc);
        for (int i = 0; i < wc; i++)
            chk(win_data[8*i +: 8] == mq[i], "R5/R9 byte", win_data[8*i +: 8], mq[i]);
        chk(consume_err == err_exp, "R6 flag", consume_err, err_exp);
        held = (mq.size() == 0) ? 0 : ((head_addr % LINE) + mq.size() + LINE - 1) / LINE;
        chk(held + outst <= 2, "R4 occupancy", held + outst, 2);
        if (hold_prev)
            chk(mem_req_valid && mem_req_addr == hold_addr, "R3 hold", mem_req_addr, hold_addr);
        if (mem_req_valid)
            chk(mem_req_tag == TAG_W'(epoch), "R2 tag", mem_req_tag, epoch);
    endtask

    // one clock: check at negedge, drive, advance model, wait for next negedge
    task automatic cycle(input bit fl, input logic [31:0] fa, input int cn);
        bit          deliver;
        bit          hs;
        logic [31:0] ra;
        int          rt;
        int          wc;
        compare_outputs();
        deliver = 0; ra = 0; rt = 0;
        flush = fl; flush_addr = fa; consume = CN_W'(cn); mem_req_ready = ready_en;
        if (rsp_en && pa.size() > 0) begin
            ra = pa.pop_front(); rt = pt.pop_front(); deliver = 1;
            mem_rsp_valid = 1'b1; mem_rsp_tag = TAG_W'(rt);
            for (int b = 0; b < LINE; b++) mem_rsp_data[8*b +: 8] = mbyte(ra + 32'(b));
        end else begin
            mem_rsp_valid = 1'b0;
        end
        hs = mem_req_valid && ready_en;
        hold_prev = mem_req_valid && !ready_en && !fl;
        hold_addr = mem_req_addr;
        if (hs) begin pa.push_back(mem_req_addr); pt.push_back(int'(mem_req_tag)); end
        if (fl) begin
            mq.delete();
            epoch = (epoch + 1) % 4;
            next_addr = fa & ~32'(LINE - 1);
            head_addr = fa;
            skip = int'(fa % LINE);
            outst = 0;
            err_exp = 0;
        end else begin
            wc = (mq.size() > WIN) ? WIN : mq.size();
            if (cn > wc) err_exp = 1;
            else begin
                err_exp = 0;
                for (int k = 0; k < cn; k++) void'(mq.pop_front());
                head_addr = head_addr + 32'(cn);
            end
            if (hs) begin
                chk(mem_req_addr == next_addr, "R2/R7 addr", mem_req_addr, next_addr);
                next_addr = next_addr + LINE;
                outst++;
            end
            if (deliver && rt == epoch) begin
                for (int b = skip; b < LINE; b++) mq.push_back(mbyte(ra + 32'(b)));
                skip = 0;
                outst--;
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(win_count == 0, "R1 count", win_count, 0);
            chk(mem_req_valid == 0, "R1 req", mem_req_valid, 0);
            chk(consume_err == 0, "R1 flag", consume_err, 0);
        end
        rst_n = 1'b1;

        // R4: decode stalled, both lines fill
        ready_en = 1; rsp_en = 1;
        for (int i = 0; i < 16; i++) cycle(0, 0, 0);
        ready_en = 0; rsp_en = 0;
        for (int i = 0; i < 4; i++) begin
            chk(win_count == 8, "R4 two lines buffered", win_count, 8);
            if (i == 0) begin
                cycle(0, 0, 12);   // R6: over-consume ignored
                chk(consume_err == 1, "R6 flag raised", consume_err, 1);
                chk(win_count == 8 && win_data[7:0] == mbyte(0), "R6 no advance", win_data[7:0], mbyte(0));
            end
            cycle(0, 0, 8);
        end
        chk(win_count == 0, "R4 drained", win_count, 0);

        // R5/R7: variable consumption, straddling, refills
        ready_en = 1; rsp_en = 1;
        for (int k = 0; k < 120; k++) begin
            rsp_en = (k % 7) != 3;
            cycle(0, 0, (k * 5) % 9);
        end

        // R9: flush while a request is in flight, stale line arrives later
        rsp_en = 0;
        for (int i = 0; i < 10 && pa.size() == 0; i++) cycle(0, 0, 1);
        cycle(1, 32'h0000_1237, 0);
        rsp_en = 1;
        cycle(0, 0, 0);
        chk(win_count == 0, "R9 stale line dropped", win_count, 0);
        for (int i = 0; i < 6; i++) cycle(0, 0, 0);
        chk(win_count == 8 && win_data[7:0] == mbyte(32'h1237), "R8 leading bytes skipped",
            win_data[7:0], mbyte(32'h1237));
        for (int k = 0; k < 40; k++) cycle(0, 0, (k * 3) % 9);

        // R9: response landing in the flush cycle itself
        rsp_en = 0;
        for (int i = 0; i < 10 && pa.size() == 0; i++) cycle(0, 0, 0);
        rsp_en = 1;
        cycle(1, 32'h0000_2000, 0);
        chk(win_count == 0, "R9 flush-cycle response dropped", win_count, 0);
        for (int k = 0; k < 30; k++) cycle(0, 0, (k * 7) % 9);

        // R10: flush with an over-large consume in the same cycle
        cycle(1, 32'h0000_400F, 15);
        chk(consume_err == 0, "R10 no flag after flush", consume_err, 0);
        chk(win_count == 0, "R8 window empty", win_count, 0);
        for (int k = 0; k < 40; k++) cycle(0, 0, (k % 4 == 0) ? 9 : k % 9);
        for (int k = 0; k < 10; k++) cycle(0, 0, 0);

        summary();
        $finish;
    end
endmodule